// File: doc/BRIEF.md
# Hierarchical State-Enable Register Bank

This block holds the state-enable control registers of a hart in three tiers: machine, hypervisor and supervisor, with four registers per tier. Each bit of a register grants code at a lower privilege level access to one piece of extension state. Software reads and writes the registers through a CSR access port that decodes a 12-bit address. Each register carries a static per-bit writable mask. A lower-tier bit can only ever read as one when the same bit is one in every tier above it.

The raw stored bits are never changed by masking. Only the effective value, which is the stored value ANDed with the live permission of the higher tiers, is read back and exported. If a higher tier later grants a bit again, the lower-tier value that was stored earlier shows again. When the hart runs in virtualized supervisor mode, a supervisor-tier access also sees the hypervisor tier as an extra filter. With a 32-bit register width, separate addresses expose the upper halves of the machine and hypervisor registers.

The effective enable vectors of every tier are exported as flat buses, so that an access checker elsewhere can use them. Raising traps and making the privilege decision are outside this block.

Top module: `stenable_bank`

## Requirements
- R1: After reset is released (two clock edges for the internal synchronizer), every machine-tier register reads zero and all exported enable vectors are zero.
- R2: Register i (i = 0..3) of the machine tier decodes at 0x30C+i, of the hypervisor tier at 0x60C+i and of the supervisor tier at 0x10C+i. Any other address gives hit = 0 and rd_data = 0, and a write to it changes no register.
- R3: Bits outside a register's writable mask read zero and ignore writes. Default masks: machine and hypervisor register 0 allow bits 0, 1, 57, 62 and 63; registers 1..3 allow only bit 63; supervisor register 0 allows bits 0 and 1, and supervisor registers 1..3 allow no bits.
- R4: While misa_f is 1, bit 1 of machine register 0 reads zero and cannot be written. As a result it also reads zero in hypervisor and supervisor register 0.
- R5: A bit that is zero in a machine register reads zero in the matching hypervisor and supervisor registers.
- R6: A supervisor-tier read with virt_mode = 1 also returns zero for every bit that is zero in the matching hypervisor register. A write in that mode cannot change such bits.
- R7: Bit 63 of every hypervisor register is writable whatever its mask parameter says, subject only to machine-tier masking.
- R8: A stored lower-tier bit is kept while a higher tier masks it, and it reads as one again once the higher tier grants the bit again.
- R9: A write to a bit that a higher tier currently masks has no effect on the stored value.
- R10: With XLEN = 32, the upper halves of the machine and hypervisor registers decode at 0x31C+i and 0x61C+i. A high-half write changes only bits 63:32, and a low write changes only bits 31:0. The supervisor tier has no high half. With XLEN = 64 the high-half addresses do not decode.
- R11: The exported vectors m_en, h_en, s_en and sv_en equal the values read back from the machine, hypervisor, supervisor (native) and supervisor (virtualized) views, with register i in bits 64*i+63 : 64*i.
- R12: Bits 63:32 of every supervisor register read zero whatever its mask parameter says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we | input | 1 | Write strobe for the addressed register |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| virt_mode | input | 1 | Access comes from virtualized supervisor mode |
| misa_f | input | 1 | Floating-point registers present; locks machine register 0 bit 1 to zero |
| hit | output | 1 | Address belongs to this bank |
| rd_data | output | XLEN | Read data for the addressed register |
| m_en | output | NREG*64 | Effective machine-tier enables |
| h_en | output | NREG*64 | Effective hypervisor-tier enables |
| s_en | output | NREG*64 | Effective supervisor-tier enables, native view |
| sv_en | output | NREG*64 | Effective supervisor-tier enables, virtualized view |

## Verification
Reads are combinational, so hit and rd_data are valid in the same cycle that the address is presented. A write becomes visible in reads and in the enable vectors right after the rising edge that captures it. Changes to misa_f and virt_mode take effect without any edge. The bench drives every input at a falling edge and samples five nanoseconds later, before the next rising edge. A write is therefore checked one cycle after it is driven, and a read in the cycle it is driven. Reset checks wait for two edges after release, to cover the synchronizer.

// File: rtl/stenable_pkg.sv
package stenable_pkg;
  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_MACH = 2'd1,
    TIER_HYP  = 2'd2,
    TIER_SUP  = 2'd3
  } tier_e;

  localparam int          ROW_W     = 64;
  localparam logic [11:0] MACH_BASE = 12'h30C;
  localparam logic [11:0] MACH_HIGH = 12'h31C;
  localparam logic [11:0] HYP_BASE  = 12'h60C;
  localparam logic [11:0] HYP_HIGH  = 12'h61C;
  localparam logic [11:0] SUP_BASE  = 12'h10C;
endpackage

// File: rtl/stenable_decode.sv
module stenable_decode
  import stenable_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 4
) (
  input  logic [11:0] addr,
  output tier_e       tier,
  output logic [1:0]  idx,
  output logic        high
);
  tier_e tier_raw;

  always_comb begin
    tier_raw = TIER_NONE;
    high     = 1'b0;
    idx      = addr[1:0];
    unique case ({addr[11:2], 2'b00})
      MACH_BASE: tier_raw = TIER_MACH;
      HYP_BASE:  tier_raw = TIER_HYP;
      SUP_BASE:  tier_raw = TIER_SUP;
      MACH_HIGH: if (XLEN == 32) begin
        tier_raw = TIER_MACH;
        high     = 1'b1;
      end
      HYP_HIGH: if (XLEN == 32) begin
        tier_raw = TIER_HYP;
        high     = 1'b1;
      end
      default: ;
    endcase
  end

  assign tier = (int'(idx) < NREG) ? tier_raw : TIER_NONE;
endmodule

// File: rtl/stenable_tier.sv
module stenable_tier #(
  parameter int                   NREG  = 4,
  parameter logic [NREG*64-1:0]   WMASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_idx,
  input  logic [63:0]        wr_lane,
  input  logic [63:0]        wr_data,
  input  logic [63:0]        wr_gate,
  input  logic [NREG*64-1:0] live,
  output logic [NREG*64-1:0] eff
);
  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic [63:0] allow;
    logic [63:0] wmask;
    logic        wsel;
    logic [63:0] store_d;
    logic [63:0] store_q;

    assign allow = WMASK[g*64 +: 64] & live[g*64 +: 64];
    assign wmask = allow & wr_lane & wr_gate;
    assign wsel  = wr_en && (wr_idx == 2'(g));
    assign eff[g*64 +: 64] = store_q & allow;

    always_comb begin
      store_d = (store_q & ~wmask) | (wr_data & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= '0;
      end else if (wsel) begin
        store_q <= store_d;
      end
    end
  end
endmodule

// File: rtl/stenable_bank.sv
module stenable_bank
  import stenable_pkg::*;
#(
  parameter int                 XLEN    = 64,
  parameter int                 NREG    = 4,
  parameter logic [NREG*64-1:0] M_WMASK = {{3{64'h8000_0000_0000_0000}}, 64'hC200_0000_0000_0003},
  parameter logic [NREG*64-1:0] H_WMASK = {{3{64'h8000_0000_0000_0000}}, 64'hC200_0000_0000_0003},
  parameter logic [NREG*64-1:0] S_WMASK = {{3{64'h0}}, 64'h0000_0000_0000_0003}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic               virt_mode,
  input  logic               misa_f,
  output logic               hit,
  output logic [XLEN-1:0]    rd_data,
  output logic [NREG*64-1:0] m_en,
  output logic [NREG*64-1:0] h_en,
  output logic [NREG*64-1:0] s_en,
  output logic [NREG*64-1:0] sv_en
);
  localparam int                 FW    = NREG * 64;
  localparam logic [FW-1:0]      H_FIX = H_WMASK | {NREG{64'h8000_0000_0000_0000}};
  localparam logic [FW-1:0]      S_FIX = S_WMASK & {NREG{64'h0000_0000_FFFF_FFFF}};

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  tier_e       dec_tier;
  logic [1:0]  dec_idx;
  logic        dec_high;

  stenable_decode #(.XLEN(XLEN), .NREG(NREG)) u_decode (
    .addr (csr_addr),
    .tier (dec_tier),
    .idx  (dec_idx),
    .high (dec_high)
  );

  assign hit = (dec_tier != TIER_NONE);

  // placement of write data in the 64-bit row
  logic [63:0] lane;
  logic [63:0] wdata64;
  logic [63:0] sel64;

  if (XLEN == 64) begin : g_rv64
    assign lane    = '1;
    assign wdata64 = csr_wdata;
    assign rd_data = sel64;
  end else begin : g_rv32
    assign lane    = dec_high ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    assign wdata64 = dec_high ? {csr_wdata, 32'h0} : {32'h0, csr_wdata};
    assign rd_data = dec_high ? sel64[63:32] : sel64[31:0];
  end

  // live permission for the machine tier: fcsr bit locked when F present
  logic [FW-1:0] m_live;
  assign m_live = ~(FW'(misa_f) << 1);

  // rows of the addressed register in each view
  logic [63:0] m_row, h_row, s_row, sv_row;
  always_comb begin
    m_row  = '0;
    h_row  = '0;
    s_row  = '0;
    sv_row = '0;
    for (int i = 0; i < NREG; i++) begin
      if (dec_idx == 2'(i)) begin
        m_row  = m_en[i*64 +: 64];
        h_row  = h_en[i*64 +: 64];
        s_row  = s_en[i*64 +: 64];
        sv_row = sv_en[i*64 +: 64];
      end
    end
  end

  logic        m_we, h_we, s_we;
  logic [63:0] s_gate;
  assign m_we   = csr_we && (dec_tier == TIER_MACH);
  assign h_we   = csr_we && (dec_tier == TIER_HYP);
  assign s_we   = csr_we && (dec_tier == TIER_SUP);
  assign s_gate = virt_mode ? h_row : '1;

  stenable_tier #(.NREG(NREG), .WMASK(M_WMASK)) u_mach (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (m_we),
    .wr_idx  (dec_idx),
    .wr_lane (lane),
    .wr_data (wdata64),
    .wr_gate ('1),
    .live    (m_live),
    .eff     (m_en)
  );

  stenable_tier #(.NREG(NREG), .WMASK(H_FIX)) u_hyp (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (h_we),
    .wr_idx  (dec_idx),
    .wr_lane (lane),
    .wr_data (wdata64),
    .wr_gate ('1),
    .live    (m_en),
    .eff     (h_en)
  );

  stenable_tier #(.NREG(NREG), .WMASK(S_FIX)) u_sup (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (s_we),
    .wr_idx  (dec_idx),
    .wr_lane (lane),
    .wr_data (wdata64),
    .wr_gate (s_gate),
    .live    (m_en),
    .eff     (s_en)
  );

  assign sv_en = s_en & h_en;

  always_comb begin
    unique case (dec_tier)
      TIER_MACH: sel64 = m_row;
      TIER_HYP:  sel64 = h_row;
      TIER_SUP:  sel64 = virt_mode ? sv_row : s_row;
      default:   sel64 = '0;
    endcase
  end
endmodule

// File: rtl/stenable_bank_chk.sv
module stenable_bank_chk #(
  parameter int XLEN = 64,
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csr_we,
  input logic               misa_f,
  input logic               hit,
  input logic [XLEN-1:0]    rd_data,
  input logic [NREG*64-1:0] m_en,
  input logic [NREG*64-1:0] h_en,
  input logic [NREG*64-1:0] s_en,
  input logic [NREG*64-1:0] sv_en
);
  localparam logic [NREG*64-1:0] UPPER = {NREG{64'hFFFF_FFFF_0000_0000}};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (m_en == '0));

  assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0));

  assert_fcsr_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    misa_f |-> !m_en[1]);

  assert_hyp_below_mach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_en & ~m_en) == '0);

  assert_sup_below_mach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en & ~m_en) == '0);

  assert_virt_below_hyp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_en & ~h_en) == '0);

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> ($stable(m_en) || !$stable(misa_f)));

  assert_sup_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en & UPPER) == '0);
endmodule

bind stenable_bank stenable_bank_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csr_we  (csr_we),
  .misa_f  (misa_f),
  .hit     (hit),
  .rd_data (rd_data),
  .m_en    (m_en),
  .h_en    (h_en),
  .s_en    (s_en),
  .sv_en   (sv_en)
);

// File: tb/test_stenable_bank.sv
`timescale 1ns/1ps
module test_stenable_bank;
  localparam int NREG = 4;
  localparam logic [255:0] MW = {{3{64'h8000_0000_0000_0000}}, 64'hC200_0000_0000_0003};
  localparam logic [255:0] HW = MW;
  localparam logic [255:0] SW = {{3{64'h0}}, 64'h0000_0000_0000_0003};
  localparam logic [63:0]  ALL0 = 64'hC200_0000_0000_0003;
  localparam logic [63:0]  B63  = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic        we, virt, misa;
  logic [11:0] addr;
  logic [63:0] wdata;
  logic        hit;
  logic [63:0] rd;
  logic [255:0] m_en, h_en, s_en, sv_en;

  logic        we32;
  logic [11:0] addr32;
  logic [31:0] wdata32;
  logic        hit32;
  logic [31:0] rd32;
  logic [255:0] m32, h32, s32, sv32;

  stenable_bank #(.XLEN(64), .NREG(NREG)) i_stenable_bank (
    .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
    .virt_mode(virt), .misa_f(misa), .hit(hit), .rd_data(rd),
    .m_en(m_en), .h_en(h_en), .s_en(s_en), .sv_en(sv_en)
  );

  stenable_bank #(.XLEN(32), .NREG(NREG)) i_stenable_bank_rv32 (
    .clk(clk), .rst_n(rst_n), .csr_we(we32), .csr_addr(addr32), .csr_wdata(wdata32),
    .virt_mode(1'b0), .misa_f(1'b0), .hit(hit32), .rd_data(rd32),
    .m_en(m32), .h_en(h32), .s_en(s32), .sv_en(sv32)
  );

  // reference model of the stored values (64-bit instance)
  logic [63:0] ms [4];
  logic [63:0] hs [4];
  logic [63:0] ss [4];

  function automatic logic [63:0] m_live(input int i);
    return MW[i*64 +: 64] & ((i == 0 && misa) ? ~64'h2 : ~64'h0);
  endfunction
  function automatic logic [63:0] m_eff(input int i);
    return ms[i] & m_live(i);
  endfunction
  function automatic logic [63:0] h_eff(input int i);
    return hs[i] & (HW[i*64 +: 64] | B63) & m_eff(i);
  endfunction
  function automatic logic [63:0] s_eff(input int i);
    return ss[i] & SW[i*64 +: 64] & 64'h0000_0000_FFFF_FFFF & m_eff(i);
  endfunction
  function automatic logic [63:0] sv_eff(input int i);
    return s_eff(i) & h_eff(i);
  endfunction

  // {hit, data}
  function automatic logic [64:0] exp_read(input logic [11:0] a);
    int i;
    i = int'(a[1:0]);
    case ({a[11:2], 2'b00})
      12'h30C: return {1'b1, m_eff(i)};
      12'h60C: return {1'b1, h_eff(i)};
      12'h10C: return {1'b1, virt ? sv_eff(i) : s_eff(i)};
      default: return {1'b0, 64'h0};
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [63:0] d);
    int i;
    logic [63:0] wm;
    i = int'(a[1:0]);
    case ({a[11:2], 2'b00})
      12'h30C: begin wm = m_live(i); ms[i] = (ms[i] & ~wm) | (d & wm); end
      12'h60C: begin wm = (HW[i*64 +: 64] | B63) & m_eff(i); hs[i] = (hs[i] & ~wm) | (d & wm); end
      12'h10C: begin
        wm = SW[i*64 +: 64] & 64'h0000_0000_FFFF_FFFF & m_eff(i) & (virt ? h_eff(i) : ~64'h0);
        ss[i] = (ss[i] & ~wm) | (d & wm);
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic v, input logic f);
    @(negedge clk);
    virt = v;
    misa = f;
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd64(input string req, input logic [11:0] a);
    logic [64:0] e;
    @(negedge clk);
    addr = a;
    #5;
    e = exp_read(a);
    chk({req, " hit"}, {63'h0, hit}, {63'h0, e[64]});
    chk({req, " data"}, rd, e[63:0]);
  endtask

  task automatic chk_vectors(input string req);
    for (int i = 0; i < NREG; i++) begin
      chk({req, " m_en"},  m_en[i*64 +: 64],  m_eff(i));
      chk({req, " h_en"},  h_en[i*64 +: 64],  h_eff(i));
      chk({req, " s_en"},  s_en[i*64 +: 64],  s_eff(i));
      chk({req, " sv_en"}, sv_en[i*64 +: 64], sv_eff(i));
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr32 = a; wdata32 = d; we32 = 1'b1;
    @(negedge clk);
    we32 = 1'b0;
  endtask

  task automatic rd32_chk(input string req, input logic [11:0] a, input logic eh, input logic [31:0] ed);
    @(negedge clk);
    addr32 = a;
    #5;
    chk({req, " hit"}, {63'h0, hit32}, {63'h0, eh});
    chk({req, " data"}, {32'h0, rd32}, {32'h0, ed});
  endtask

  function automatic logic [11:0] pick_addr(input int sel);
    case (sel / 4)
      0: return 12'h30C + 12'(sel % 4);
      1: return 12'h60C + 12'(sel % 4);
      2: return 12'h10C + 12'(sel % 4);
      default: case (sel % 4)
        0: return 12'h30B;
        1: return 12'h310;
        2: return 12'h31C;
        default: return 12'h11C;
      endcase
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    we = 1'b0; virt = 1'b0; misa = 1'b0; addr = '0; wdata = '0;
    we32 = 1'b0; addr32 = '0; wdata32 = '0;
    for (int i = 0; i < 4; i++) begin ms[i] = '0; hs[i] = '0; ss[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd64("R1 mach0 after reset", 12'h30C);
    chk("R1 m_en after reset", m_en[63:0] | m_en[255:192], 64'h0);
    chk_vectors("R1");

    // R3: machine mask
    wr64(12'h30C, '1);
    rd64("R3 mach0 mask", 12'h30C);
    chk("R3 mach0 value", rd, ALL0);
    wr64(12'h30D, '1);
    rd64("R3 mach1 only bit63", 12'h30D);
    chk("R3 mach1 value", rd, B63);

    // R12 / R3: supervisor mask and upper half
    wr64(12'h10C, '1);
    rd64("R12 sup0 upper zero", 12'h10C);
    chk("R12 sup0 value", rd, 64'h3);

    // R5 / R7: hypervisor tier
    wr64(12'h60C, '1);
    rd64("R5 hyp0 under mach", 12'h60C);
    wr64(12'h60D, '1);
    rd64("R7 hyp1 bit63 writable", 12'h60D);
    chk("R7 hyp1 value", rd, B63);

    // R4: F present locks bit 1
    set_mode(1'b0, 1'b1);
    rd64("R4 mach0 with F", 12'h30C);
    chk("R4 mach0 value", rd, ALL0 & ~64'h2);
    rd64("R4 sup0 with F", 12'h10C);
    chk("R4 sup0 value", rd, 64'h1);
    wr64(12'h30C, 64'h0);
    wr64(12'h30C, '1);
    set_mode(1'b0, 1'b0);
    rd64("R8 mach0 bit1 kept", 12'h30C);
    chk("R8 mach0 value", rd, ALL0);

    // R6: virtualized supervisor view
    wr64(12'h60C, 64'h1);
    set_mode(1'b1, 1'b0);
    rd64("R6 sup0 virt view", 12'h10C);
    chk("R6 sup0 virt value", rd, 64'h1);
    wr64(12'h10C, 64'h0);
    set_mode(1'b0, 1'b0);
    rd64("R6 sup0 virt write gated", 12'h10C);
    chk("R6 sup0 native value", rd, 64'h2);
    wr64(12'h10C, 64'h3);

    // R9 / R8: writes under masking, stored values kept
    wr64(12'h30C, 64'h0);
    rd64("R5 hyp0 masked", 12'h60C);
    chk("R5 hyp0 value", rd, 64'h0);
    wr64(12'h60C, '1);
    wr64(12'h10C, 64'h0);
    wr64(12'h30C, '1);
    rd64("R9 hyp0 write ignored", 12'h60C);
    chk("R9 hyp0 value", rd, 64'h1);
    rd64("R8 sup0 restored", 12'h10C);
    chk("R8 sup0 value", rd, 64'h3);

    // R2: address decode
    rd64("R2 below range", 12'h30B);
    wr64(12'h310, '1);
    wr64(12'h30B, 64'h0);
    for (int i = 0; i < 4; i++) rd64("R2 mach unchanged", 12'h30C + 12'(i));
    rd64("R10 rv64 high half absent", 12'h31C);
    chk_vectors("R11 directed");

    // random phase
    void'($urandom(32'd7331));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      logic [11:0] a;
      logic [63:0] d;
      r = $urandom;
      set_mode(r[8], (r[3:0] == 4'd0) ? r[9] : misa);
      a = pick_addr(int'($urandom % 16));
      d = r[5] ? '1 : {$urandom, $urandom};
      if (r[4]) wr64(a, d);
      rd64("R2 R3 R5 R6 random read", a);
      chk_vectors("R11 random");
    end

    // R10: 32-bit register width
    rd32_chk("R10 rv32 mach0 reset", 12'h30C, 1'b1, 32'h0);
    wr32(12'h30C, 32'hFFFF_FFFF);
    rd32_chk("R10 rv32 mach0 low", 12'h30C, 1'b1, 32'h3);
    rd32_chk("R10 rv32 mach0 high untouched", 12'h31C, 1'b1, 32'h0);
    wr32(12'h31C, 32'hFFFF_FFFF);
    rd32_chk("R10 rv32 mach0 high", 12'h31C, 1'b1, 32'hC200_0000);
    rd32_chk("R10 rv32 mach0 low kept", 12'h30C, 1'b1, 32'h3);
    wr32(12'h61C, 32'hFFFF_FFFF);
    rd32_chk("R10 rv32 hyp0 high", 12'h61C, 1'b1, 32'hC200_0000);
    rd32_chk("R10 rv32 hyp0 low", 12'h60C, 1'b1, 32'h0);
    rd32_chk("R10 rv32 no sup high", 12'h11C, 1'b0, 32'h0);
    chk("R11 rv32 m_en row0", m32[63:0], ALL0);
    chk("R11 rv32 h_en row0", h32[63:0], 64'hC200_0000_0000_0000);
    chk("R11 rv32 sv_en row0", sv32[63:0], s32[63:0] & h32[63:0]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule